// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between the comparator logic of a set of timer channels and the interrupt controller. Each channel hands it a one-cycle fire pulse together with its 64-bit configuration word. The router works out which of the interrupt lines the fire belongs to and emits a one-cycle pulse on that line. Delivery is edge-only.

A global legacy mode overrides routing for the two lowest channels. In that mode, channel 0 goes to line 0 and channel 1 goes to line 8, whatever their route fields hold. While the mode is on, the block also tells the legacy interval-timer tick source to stay quiet.

In normal mode, every channel's 5-bit route field is checked against its own 32-bit capability mask. A forbidden route delivers nothing and raises a sticky error flag, and so does a request for level-type delivery. The error flag stays set until a clear pulse arrives.

Top module: `timer_irq_router`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all `irq` lines, `route_err` and `legacy_quiet` are low.
- R2: Take a channel whose config bit 1 is 0 and which is not under legacy override. If its route field (config bits 13:9) is below NUM_LINES and its capability bit at that route is set (capability is config bits 63:32), then a fire on it gives a pulse of exactly one cycle on `irq[route]`. The pulse appears at the clock edge that samples the fire.
- R3: A fire on a channel whose capability bit at its route is clear asserts no line and sets `route_err` at the same edge.
- R4: Channels that fire in the same cycle on different lines are all delivered at the same edge. Channels that fire on a shared line produce a single pulse on it.
- R5: With `legacy_mode` high, channel 0 drives line 0 and channel 1 drives line 8. Their route fields and capability masks are ignored and cannot raise an error. Channel 2 and above route as in R2.
- R6: `legacy_quiet` equals `legacy_mode` as sampled at the previous clock edge.
- R7: A fire on a channel whose config bit 1 (level type) is set delivers nothing and sets `route_err`. This holds in legacy mode too.
- R8: A line that pulsed in the previous cycle and is requested again is held low for one cycle and pulsed in the next cycle. Every request that arrives during that wait merges into the same pulse.
- R9: `route_err` stays set until `err_clr` is high at a clock edge with no new error. A new error in the same cycle as `err_clr` keeps the flag set.
- R10: A route value of NUM_LINES or above is treated as invalid even when its capability bit is set. It raises `route_err` and asserts no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Global legacy override for channels 0 and 1 |
| fire | input | NUM_TIMERS | One-cycle fire pulse per channel |
| tmr_cfg | input | NUM_TIMERS*64 | Config word per channel, channel t at bits [64t+63:64t] |
| err_clr | input | 1 | Clears the sticky error flag |
| irq | output | NUM_LINES | Registered interrupt line pulses |
| legacy_quiet | output | 1 | Suppress request to the legacy tick source |
| route_err | output | 1 | Sticky routing/level error flag |

## Verification
The bench builds the block with three channels and 24 lines. With those values, the two legacy-owned channels and one channel that is never overridden are all present. Route values 24 to 31 remain encodable, so the out-of-range rule can be hit even when the capability bit is set. Random stimulus concentrates routes on lines 20 to 23, so channels collide on shared lines and fire again on the same line in consecutive cycles often. It also mixes in arbitrary masks, level requests and legacy toggles.

// File: rtl/trr_pkg.sv
package trr_pkg;
  localparam int CFG_W   = 64;
  localparam int LVL_BIT = 1;
  localparam int RT_LSB  = 9;
  localparam int RT_W    = 5;
  localparam int CAP_LSB = 32;
  localparam int CAP_W   = 32;

  typedef logic [RT_W-1:0]  route_t;
  typedef logic [CAP_W-1:0] cap_t;
endpackage

// File: rtl/trr_decode.sv
module trr_decode
  import trr_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter bit LEG_OWNED = 1'b0,
  parameter int LEG_LINE  = 0
) (
  input  logic                 fire,
  input  logic [CFG_W-1:0]     cfg,
  input  logic                 legacy_mode,
  output logic [NUM_LINES-1:0] req,
  output logic                 bad
);
  route_t               route;
  cap_t                 cap;
  logic                 lvl;
  logic [NUM_LINES-1:0] hit;
  logic                 unused_cfg_bits;

  assign route = cfg[RT_LSB +: RT_W];
  assign cap   = cfg[CAP_LSB +: CAP_W];
  assign lvl   = cfg[LVL_BIT];
  assign unused_cfg_bits = ^{cfg[CAP_LSB-1:RT_LSB+RT_W], cfg[RT_LSB-1:LVL_BIT+1], cfg[0]};

  always_comb begin
    hit = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (route == RT_W'(l)) hit[l] = 1'b1;
    end
  end

  always_comb begin
    req = '0;
    bad = 1'b0;
    if (fire) begin
      if (lvl) begin
        bad = 1'b1;
      end else if (legacy_mode && LEG_OWNED) begin
        req[LEG_LINE] = 1'b1;
      end else if (cap[route] && (hit != '0)) begin
        req = hit;
      end else begin
        bad = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trr_edge_former.sv
module trr_edge_former #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] irq_q
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] want;

  assign want = req | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= want & ~irq_q;
      pend_q <= want & irq_q;
    end
  end

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (irq_q & $past(irq_q)) == '0); // R8
  AST_PEND_DELIVERED: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0) |=> ((irq_q & $past(pend_q)) == $past(pend_q))); // R8
endmodule

// File: rtl/trr_err_track.sv
module trr_err_track (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst)      err_q <= 1'b0;
    else if (set) err_q <= 1'b1;
    else if (clr) err_q <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr) |=> err_q); // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    set |=> err_q); // R3
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
  import trr_pkg::*;
#(
  parameter int NUM_TIMERS  = 3,
  parameter int NUM_LINES   = 24,
  parameter int LEG_TIMERS  = 2,
  parameter int LEG_LINE_T0 = 0,
  parameter int LEG_LINE_T1 = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        legacy_mode,
  input  logic [NUM_TIMERS-1:0]       fire,
  input  logic [NUM_TIMERS*CFG_W-1:0] tmr_cfg,
  input  logic                        err_clr,
  output logic [NUM_LINES-1:0]        irq,
  output logic                        legacy_quiet,
  output logic                        route_err
);
  logic [NUM_TIMERS-1:0][NUM_LINES-1:0] req_by_tmr;
  logic [NUM_TIMERS-1:0]                bad_by_tmr;
  logic [NUM_LINES-1:0]                 req_all;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    localparam bit OWNED = (t < LEG_TIMERS);
    localparam int LLINE = (t == 0) ? LEG_LINE_T0 : LEG_LINE_T1;
    trr_decode #(
      .NUM_LINES(NUM_LINES),
      .LEG_OWNED(OWNED),
      .LEG_LINE (LLINE)
    ) u_dec (
      .fire       (fire[t]),
      .cfg        (tmr_cfg[t*CFG_W +: CFG_W]),
      .legacy_mode(legacy_mode),
      .req        (req_by_tmr[t]),
      .bad        (bad_by_tmr[t])
    );

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_by_tmr[t])); // R2
    AST_LEVEL_NO_LINE: assert property (@(posedge clk) disable iff (rst)
      (fire[t] && tmr_cfg[t*CFG_W + LVL_BIT]) |-> (req_by_tmr[t] == '0 && bad_by_tmr[t])); // R7
  end

  always_comb begin
    req_all = '0;
    for (int t = 0; t < NUM_TIMERS; t++) req_all = req_all | req_by_tmr[t];
  end

  trr_edge_former #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .req  (req_all),
    .irq_q(irq)
  );

  trr_err_track u_err (
    .clk  (clk),
    .rst  (rst),
    .set  (|bad_by_tmr),
    .clr  (err_clr),
    .err_q(route_err)
  );

  always_ff @(posedge clk) begin
    if (rst) legacy_quiet <= 1'b0;
    else     legacy_quiet <= legacy_mode;
  end

  AST_QUIET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (legacy_quiet == $past(legacy_mode))); // R6
endmodule

// File: tb/tb_timer_irq_router.sv
module tb_timer_irq_router;
  localparam int NT = 3;
  localparam int NL = 24;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF_CAP = 32'h00F0_0000;

  logic            clk = 1'b0;
  logic            rst;
  logic            legacy_mode;
  logic [NT-1:0]   fire;
  logic [NT*64-1:0] tmr_cfg;
  logic            err_clr;
  logic [NL-1:0]   irq;
  logic            legacy_quiet;
  logic            route_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [NL-1:0] e_irq = '0;
  logic [NL-1:0] e_pend = '0;
  logic          e_err = 1'b0;
  logic          e_sup = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_irq_router #(.NUM_TIMERS(NT), .NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .fire(fire),
    .tmr_cfg(tmr_cfg), .err_clr(err_clr), .irq(irq),
    .legacy_quiet(legacy_quiet), .route_err(route_err)
  );

  function automatic logic [63:0] mk_cfg(input int route, input logic lvl, input logic [31:0] cap);
    logic [63:0] w;
    w = '0;
    w[13:9]  = route[4:0];
    w[1]     = lvl;
    w[63:32] = cap;
    return w;
  endfunction

  function automatic logic [NL:0] model_fire(input logic leg, input logic [NT-1:0] f,
                                             input logic [NT*64-1:0] c);
    logic [NL-1:0] r;
    logic          b;
    logic [63:0]   w;
    int            rt;
    r = '0;
    b = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (f[t]) begin
        w  = c[t*64 +: 64];
        rt = int'(w[13:9]);
        if (w[1]) b = 1'b1;
        else if (leg && t < 2) r[(t == 0) ? 0 : 8] = 1'b1;
        else if (w[32+rt] && rt < NL) r[rt] = 1'b1;
        else b = 1'b1;
      end
    end
    return {b, r};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic [NL:0]   m;
    logic [NL-1:0] want;
    m     = model_fire(legacy_mode, fire, tmr_cfg);
    want  = m[NL-1:0] | e_pend;
    e_pend = want & e_irq;
    e_irq  = want & ~e_irq;
    e_err  = m[NL] | (e_err & ~err_clr);
    e_sup  = legacy_mode;
    @(negedge clk);
    check(tag, "irq", 32'(irq), 32'(e_irq));
    check(tag, "route_err", 32'(route_err), 32'(e_err));
    check(tag, "legacy_quiet", 32'(legacy_quiet), 32'(e_sup));
  endtask

  task automatic idle(input string tag, input int n);
    fire = '0;
    err_clr = 1'b0;
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic clear_err();
    fire = '0;
    err_clr = 1'b1;
    cyc("R9");
    err_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; legacy_mode = 1'b1; fire = '0; err_clr = 1'b0;
    tmr_cfg = {mk_cfg(20, 1'b0, DEF_CAP), mk_cfg(20, 1'b0, DEF_CAP), mk_cfg(20, 1'b0, DEF_CAP)};
    repeat (3) @(negedge clk);
    check("R1", "irq", 32'(irq), 32'd0);
    check("R1", "route_err", 32'(route_err), 32'd0);
    check("R1", "legacy_quiet", 32'(legacy_quiet), 32'd0);
    legacy_mode = 1'b0;
    rst = 1'b0;
    cyc("R1");

    // R2: single delivery on a permitted line
    fire = 3'b001; cyc("R2");
    fire = 3'b000; cyc("R2");
    idle("R2", 1);

    // R4: distinct lines together, then a shared line
    tmr_cfg = {mk_cfg(23, 1'b0, DEF_CAP), mk_cfg(22, 1'b0, DEF_CAP), mk_cfg(21, 1'b0, DEF_CAP)};
    fire = 3'b111; cyc("R4");
    fire = 3'b000; cyc("R4");
    tmr_cfg = {mk_cfg(21, 1'b0, DEF_CAP), mk_cfg(21, 1'b0, DEF_CAP), mk_cfg(21, 1'b0, DEF_CAP)};
    fire = 3'b111; cyc("R4");
    fire = 3'b000; idle("R4", 2);

    // R8: consecutive requests on one line are spaced by a low cycle
    tmr_cfg = {mk_cfg(22, 1'b0, DEF_CAP), mk_cfg(23, 1'b0, DEF_CAP), mk_cfg(20, 1'b0, DEF_CAP)};
    fire = 3'b001; cyc("R8");
    fire = 3'b001; cyc("R8");
    fire = 3'b001; cyc("R8");
    fire = 3'b000; idle("R8", 3);

    // R3: route not in capability mask
    tmr_cfg[127:64] = mk_cfg(5, 1'b0, DEF_CAP);
    fire = 3'b010; cyc("R3");
    fire = 3'b000;
    // R9: sticky, set wins over clear, then clear
    idle("R9", 2);
    fire = 3'b010; err_clr = 1'b1; cyc("R9");
    fire = 3'b000; cyc("R9");
    err_clr = 1'b0; idle("R9", 1);

    // R10: out-of-range line even with capability bit set
    tmr_cfg[191:128] = mk_cfg(25, 1'b0, 32'hFFFF_FFFF);
    fire = 3'b100; cyc("R10");
    fire = 3'b000; cyc("R10");
    clear_err();

    // R5, R6: legacy override ignores route and capability of channels 0 and 1
    legacy_mode = 1'b1;
    tmr_cfg = {mk_cfg(22, 1'b0, DEF_CAP), mk_cfg(31, 1'b0, 32'h0), mk_cfg(5, 1'b0, 32'h0)};
    cyc("R6");
    fire = 3'b111; cyc("R5");
    fire = 3'b000; idle("R5", 2);

    // R7: level type rejected even under legacy override
    tmr_cfg[63:0] = mk_cfg(20, 1'b1, DEF_CAP);
    fire = 3'b001; cyc("R7");
    fire = 3'b000; cyc("R7");
    clear_err();
    legacy_mode = 1'b0;
    cyc("R6");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      for (int t = 0; t < NT; t++) begin
        int sel;
        int rt;
        logic [31:0] cp;
        sel = int'($urandom_range(0, 7));
        if (sel < 5) rt = 20 + int'($urandom_range(0, 3));
        else rt = int'($urandom_range(0, 31));
        cp = ($urandom_range(0, 7) == 0) ? $urandom() : DEF_CAP;
        tmr_cfg[t*64 +: 64] = mk_cfg(rt, ($urandom_range(0, 15) == 0), cp);
      end
      fire = NT'($urandom());
      err_clr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) legacy_mode = ~legacy_mode;
      cyc("R4");
    end
    idle("R8", 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule